// File: doc/BRIEF.md
# Four-Port Bidirectional GPIO Register Bank

The block holds four 8-bit general-purpose ports behind an 8-bit register bus. Each port has three byte registers:
- an output latch;
- a direction register;
- an option register.

Reads are combinational. A read of an output latch address returns a per-pin merge. Output pins show the latch bit. Input pins show the OR of the pin level and the pin's pull-up value.

Each pin has a registered drive value. That value is updated only when a register write really changes what the pin must drive. Every such update is flagged with a one-cycle strobe per pin, so a consumer can tell exactly which pads were touched.

A 3-bit mode code per pin is derived from the pin's direction, option and latch bits. A second one-cycle strobe per pin marks each pin whose controlling register bit changed in the last write.

Top module: `gpio_bank`

## Requirements
- R1: While rst_ni is low and after it rises, all latch, direction, option and drive state is 0. pin_o, pin_oe_o, pin_upd_o and mode_chg_o are 0.
- R2: The register addresses are as follows (p is the port index 0..3):
  - output latch of port p at 0xC0+p;
  - direction of port p at 0xC4+p;
  - option of port p at 0xCC+p.

  Port p owns pin bits 8p..8p+7. pin_oe_o equals the direction register, and a direction bit of 1 makes the pin an output.
- R3: A read of 0xC0+p returns, per bit, the latch bit when the direction bit is 1. Otherwise it returns pin_i OR pullup_i for that bit.
- R4: A latch write updates the latch at the clock edge. In the cycle after that edge, pin_upd_o is 1 exactly on bits that changed and are outputs, and pin_o takes the new latch value on those bits.
- R5: A direction write makes pin_upd_o 1, in the cycle after the edge, exactly on bits whose direction changed. pin_o takes the current latch value on those bits.
- R6: The direction and option registers read back exactly the value last written.
- R7: mode_o[3k+:3] for pin k is decoded as follows:
  - output pin: 5 when the option bit is 1, 4 when it is 0;
  - input pin with latch bit 0: 0 when the option bit is 0, 1 when it is 1;
  - input pin with latch bit 1: 2 when the option bit is 0, 3 when it is 1.
- R8: In the cycle after any latch, direction or option write, mode_chg_o is 1 exactly on the bits of that port that changed in the written register.
- R9: Reads of any address other than 0xC0–0xC7 and 0xCC–0xCF return 0x00. Writes there change no state and raise no strobe.
- R10: pin_o holds its value in every cycle where pin_upd_o is 0 on that bit. pin_upd_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | 8 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| pin_i | input | 32 | Pin input levels, port p at bits 8p+7:8p |
| pullup_i | input | 32 | Per-pin pull-up values |
| pin_o | output | 32 | Registered drive value per pin |
| pin_oe_o | output | 32 | Output enable per pin (direction register) |
| pin_upd_o | output | 32 | One-cycle strobe per pin on drive update |
| mode_o | output | 96 | 3-bit mode code per pin |
| mode_chg_o | output | 32 | One-cycle strobe per pin on mode re-evaluation |

## Verification
rdata_o is combinational: it reflects addr_i, pin_i and pullup_i in the same cycle, and reflects a write once the write's clock edge has passed. All register effects of a write land at that edge:
- latch, direction and option contents;
- pin_oe_o and mode_o;
- the pin_o update;
- the pin_upd_o and mode_chg_o strobes.

The strobes then drop at the following edge. The bench drives inputs shortly after the rising edge and updates its reference model on the rising edge. It compares every output on the falling edge, which is half a cycle after the edge where each result becomes due.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_IN_PULL     = 3'd0,
    MD_IN_PULL_IRQ = 3'd1,
    MD_IN_FLOAT    = 3'd2,
    MD_IN_ANALOG   = 3'd3,
    MD_OUT_OD      = 3'd4,
    MD_OUT_PP      = 3'd5
  } pin_mode_e;

  function automatic pin_mode_e pin_mode(input logic dir, input logic dat, input logic opt);
    if (dir) return opt ? MD_OUT_PP : MD_OUT_OD;
    if (!dat) return opt ? MD_IN_PULL_IRQ : MD_IN_PULL;
    return opt ? MD_IN_ANALOG : MD_IN_FLOAT;
  endfunction

endpackage

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_dat_i,
  input  logic              wr_dir_i,
  input  logic              wr_opt_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      lat_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      opt_o,
  output logic [W-1:0]      drv_o,
  output logic [W-1:0]      upd_o,
  output logic [W-1:0]      mode_chg_o,
  output logic [W*MODE_W-1:0] mode_o
);

  logic [W-1:0] lat_q, dir_q, opt_q, drv_q, upd_q, mchg_q;
  logic [W-1:0] lat_chg, dir_chg, opt_chg, dat_upd;

  assign lat_chg = lat_q ^ wdata_i;
  assign dir_chg = dir_q ^ wdata_i;
  assign opt_chg = opt_q ^ wdata_i;
  assign dat_upd = lat_chg & dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      dir_q  <= '0;
      opt_q  <= '0;
      drv_q  <= '0;
      upd_q  <= '0;
      mchg_q <= '0;
    end else begin
      upd_q  <= '0;
      mchg_q <= '0;
      if (wr_dat_i) begin
        lat_q  <= wdata_i;
        upd_q  <= dat_upd;
        mchg_q <= lat_chg;
        drv_q  <= (drv_q & ~dat_upd) | (wdata_i & dat_upd);
      end else if (wr_dir_i) begin
        dir_q  <= wdata_i;
        upd_q  <= dir_chg;
        mchg_q <= dir_chg;
        drv_q  <= (drv_q & ~dir_chg) | (lat_q & dir_chg);
      end else if (wr_opt_i) begin
        opt_q  <= wdata_i;
        mchg_q <= opt_chg;
      end
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_mode
    assign mode_o[b*MODE_W +: MODE_W] = pin_mode(dir_q[b], lat_q[b], opt_q[b]);
  end

  assign lat_o      = lat_q;
  assign dir_o      = dir_q;
  assign opt_o      = opt_q;
  assign drv_o      = drv_q;
  assign upd_o      = upd_q;
  assign mode_chg_o = mchg_q;

  // R4
  upd_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|upd_q) |-> $past(wr_dat_i || wr_dir_i));

  // R10
  drv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_q == '0) |-> $stable(drv_q));

  // R6
  dir_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir_i |=> (dir_q == $past(wdata_i)));

  // R8
  mchg_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mchg_q) |-> $past(wr_dat_i || wr_dir_i || wr_opt_i));

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux #(
  parameter int unsigned NP     = 4,
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              in_range_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [NP*W-1:0]   lat_i,
  input  logic [NP*W-1:0]   dir_i,
  input  logic [NP*W-1:0]   opt_i,
  input  logic [NP*W-1:0]   pin_i,
  input  logic [NP*W-1:0]   pullup_i,
  output logic [W-1:0]      rdata_o
);

  localparam int unsigned DIR_OFS = NP;
  localparam int unsigned OPT_OFS = 3 * NP;

  always_comb begin
    rdata_o = '0;
    if (in_range_i) begin
      for (int p = 0; p < NP; p++) begin
        if (off_i == ADDR_W'(p))
          rdata_o = (lat_i[p*W +: W] & dir_i[p*W +: W]) |
                    ((pin_i[p*W +: W] | pullup_i[p*W +: W]) & ~dir_i[p*W +: W]);
        if (off_i == ADDR_W'(p + DIR_OFS)) rdata_o = dir_i[p*W +: W];
        if (off_i == ADDR_W'(p + OPT_OFS)) rdata_o = opt_i[p*W +: W];
      end
    end
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NP     = 4,
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR_W = 8,
  parameter logic [7:0]  BASE   = 8'hC0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [W-1:0]          wdata_i,
  output logic [W-1:0]          rdata_o,
  input  logic [NP*W-1:0]       pin_i,
  input  logic [NP*W-1:0]       pullup_i,
  output logic [NP*W-1:0]       pin_o,
  output logic [NP*W-1:0]       pin_oe_o,
  output logic [NP*W-1:0]       pin_upd_o,
  output logic [NP*W*MODE_W-1:0] mode_o,
  output logic [NP*W-1:0]       mode_chg_o
);

  localparam int unsigned SPAN    = 4 * NP;
  localparam int unsigned DIR_OFS = NP;
  localparam int unsigned OPT_OFS = 3 * NP;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

  logic [ADDR_W-1:0] off;
  logic              in_range;
  logic [NP*W-1:0]   lat, dir, opt;

  assign off      = addr_i - BASE_A;
  assign in_range = (addr_i >= BASE_A) && (off < ADDR_W'(SPAN));

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic wr_dat, wr_dir, wr_opt;
    assign wr_dat = wr_en_i && in_range && (off == ADDR_W'(p));
    assign wr_dir = wr_en_i && in_range && (off == ADDR_W'(p + DIR_OFS));
    assign wr_opt = wr_en_i && in_range && (off == ADDR_W'(p + OPT_OFS));

    gpio_port #(.W(W)) u_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_dat_i   (wr_dat),
      .wr_dir_i   (wr_dir),
      .wr_opt_i   (wr_opt),
      .wdata_i    (wdata_i),
      .lat_o      (lat[p*W +: W]),
      .dir_o      (dir[p*W +: W]),
      .opt_o      (opt[p*W +: W]),
      .drv_o      (pin_o[p*W +: W]),
      .upd_o      (pin_upd_o[p*W +: W]),
      .mode_chg_o (mode_chg_o[p*W +: W]),
      .mode_o     (mode_o[p*W*MODE_W +: W*MODE_W])
    );
  end

  gpio_rd_mux #(.NP(NP), .W(W), .ADDR_W(ADDR_W)) u_rd_mux (
    .in_range_i (in_range),
    .off_i      (off),
    .lat_i      (lat),
    .dir_i      (dir),
    .opt_i      (opt),
    .pin_i      (pin_i),
    .pullup_i   (pullup_i),
    .rdata_o    (rdata_o)
  );

  assign pin_oe_o = dir;

  // R9
  unmapped_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_range |-> (rdata_o == '0));

endmodule

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;

  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wdata = 8'h00;
  logic [31:0] pin_in = 32'h0;
  logic [31:0] pull = 32'h0;
  logic [7:0]  rdata;
  logic [31:0] pin_o, pin_oe, pin_upd, mode_chg;
  logic [95:0] mode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  gpio_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pullup_i(pull), .pin_o(pin_o), .pin_oe_o(pin_oe),
    .pin_upd_o(pin_upd), .mode_o(mode), .mode_chg_o(mode_chg)
  );

  // reference model
  logic [7:0]  m_lat [4];
  logic [7:0]  m_dir [4];
  logic [7:0]  m_opt [4];
  logic [31:0] m_drv, m_upd, m_mchg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 4; p++) begin m_lat[p] = 0; m_dir[p] = 0; m_opt[p] = 0; end
      m_drv = 0; m_upd = 0; m_mchg = 0;
    end else begin
      m_upd = 0; m_mchg = 0;
      if (wr_en) begin
        if (addr >= 8'hC0 && addr <= 8'hC3) begin
          int p; logic [7:0] ch;
          p = addr - 8'hC0;
          ch = m_lat[p] ^ wdata;
          m_mchg[p*8 +: 8] = ch;
          for (int b = 0; b < 8; b++)
            if (ch[b] && m_dir[p][b]) begin m_upd[p*8+b] = 1; m_drv[p*8+b] = wdata[b]; end
          m_lat[p] = wdata;
        end else if (addr >= 8'hC4 && addr <= 8'hC7) begin
          int p; logic [7:0] ch;
          p = addr - 8'hC4;
          ch = m_dir[p] ^ wdata;
          m_mchg[p*8 +: 8] = ch;
          for (int b = 0; b < 8; b++)
            if (ch[b]) begin m_upd[p*8+b] = 1; m_drv[p*8+b] = m_lat[p][b]; end
          m_dir[p] = wdata;
        end else if (addr >= 8'hCC && addr <= 8'hCF) begin
          int p;
          p = addr - 8'hCC;
          m_mchg[p*8 +: 8] = m_opt[p] ^ wdata;
          m_opt[p] = wdata;
        end
      end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    int p;
    if (a >= 8'hC0 && a <= 8'hC3) begin
      p = a - 8'hC0;
      for (int b = 0; b < 8; b++)
        exp_rd[b] = m_dir[p][b] ? m_lat[p][b] : (pin_in[p*8+b] | pull[p*8+b]);
    end else if (a >= 8'hC4 && a <= 8'hC7) exp_rd = m_dir[a - 8'hC4];
    else if (a >= 8'hCC && a <= 8'hCF) exp_rd = m_opt[a - 8'hCC];
    else exp_rd = 8'h00;
  endfunction

  function automatic logic [95:0] exp_mode();
    for (int k = 0; k < 32; k++) begin
      logic d, l, o; int c;
      d = m_dir[k/8][k%8]; l = m_lat[k/8][k%8]; o = m_opt[k/8][k%8];
      if (d) c = o ? 5 : 4;
      else c = (l ? 2 : 0) + (o ? 1 : 0);
      exp_mode[k*3 +: 3] = 3'(c);
    end
  endfunction

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t act=%h exp=%h", req, $time, act, exp);
    end
  endtask

  // per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (!done) begin
      logic [31:0] oe;
      for (int p = 0; p < 4; p++) oe[p*8 +: 8] = m_dir[p];
      if (!rst_n) begin
        chk("R1 pin_o", {64'h0, pin_o}, 96'h0);
        chk("R1 pin_upd", {64'h0, pin_upd}, 96'h0);
        chk("R1 mode_chg", {64'h0, mode_chg}, 96'h0);
        chk("R1 oe", {64'h0, pin_oe}, 96'h0);
      end else begin
        if (addr >= 8'hC0 && addr <= 8'hC3) chk("R3 rdata", {88'h0, rdata}, {88'h0, exp_rd(addr)});
        else if ((addr >= 8'hC4 && addr <= 8'hC7) || (addr >= 8'hCC && addr <= 8'hCF))
          chk("R6 rdata", {88'h0, rdata}, {88'h0, exp_rd(addr)});
        else chk("R9 rdata", {88'h0, rdata}, 96'h0);
        chk("R4 R5 R10 pin_o", {64'h0, pin_o}, {64'h0, m_drv});
        chk("R4 R5 pin_upd", {64'h0, pin_upd}, {64'h0, m_upd});
        chk("R2 pin_oe", {64'h0, pin_oe}, {64'h0, oe});
        chk("R7 mode", mode, exp_mode());
        chk("R8 mode_chg", {64'h0, mode_chg}, {64'h0, m_mchg});
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(posedge clk); #1;
    wr_en = 1'b0; addr = a;
  endtask

  initial begin
    repeat (3) @(posedge clk);   // R1 checked while in reset
    #1 rst_n = 1'b1;
    rd(8'hC0); rd(8'hC4);                      // R1 after reset
    pin_in = 32'h5A3C_0F81; pull = 32'h0100_2002;
    rd(8'hC0); rd(8'hC3);                      // R3 all inputs
    wr(8'hC4, 8'hF0);                          // R2 R5 dir A, latch 0
    wr(8'hC0, 8'hAA);                          // R4 only high nibble drives
    wr(8'hC0, 8'hAA);                          // R4 no change, no strobe
    wr(8'hC0, 8'h5A);                          // R4 partial change
    rd(8'hC0);                                 // R3 mixed merge
    wr(8'hC4, 8'h0F);                          // R5 all bits flip
    wr(8'hCC, 8'h3C);                          // R7 R8 option
    rd(8'hCC); rd(8'hC4);                      // R6
    wr(8'hC8, 8'hFF); rd(8'hC8);               // R9 unmapped
    wr(8'hD0, 8'hFF); wr(8'hBF, 8'h77); rd(8'hD0); rd(8'hC0);
    wr(8'hC7, 8'hFF); wr(8'hC3, 8'h81);        // R2 port D
    wr(8'hCF, 8'hFF); rd(8'hC3);
    for (int i = 0; i < 800; i++) begin
      @(posedge clk); #1;
      wr_en = 1'($urandom_range(0, 1));
      addr  = 8'(8'hBC + $urandom_range(0, 23));
      wdata = 8'($urandom);
      if ($urandom_range(0, 3) == 0) begin pin_in = $urandom; pull = $urandom; end
    end
    @(posedge clk); #1 wr_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_T * 200000);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule